// File: doc/BRIEF.md
# Windowed Display Memory Address Sequencer

The block produces the line and column address that a host uses to reach a display memory of 128 pixel columns by 162 lines. The host sets a rectangular window through a small register interface: a column start and end, and a line start and end. After that, every access strobe moves the column address on by one. When the column reaches the window's right edge, it returns to the column start and the line moves down by one. When the line also reaches the window's bottom edge, it returns to the line start. The host can therefore stream a whole window of pixels without setting the address again.

A mode register selects the access width and the column direction. In narrow (byte) access each pixel column occupies two addresses, so the column range is 0 to 255. In wide (16-bit) access it is 0 to 127. A mirror bit reverses the column order, which lets a panel be mounted either way round. The memory's read path returns stale latched data on the first read after the address is set or after a write. The sequencer treats that read as a dummy: the address does not move, and a flag marks which reads carry fresh data.

Top module: `wac_top`

## Requirements
- R1: During and after reset: ram_row = 0, ram_col = 0, narrow access, direct column order, window spanning columns 0..255 and lines 0..161, and a dummy read pending.
- R2: A write on cfg_we stores cfg_data into the register named by cfg_sel: 0 column start, 1 column end, 2 line start, 3 line end, 4 mode (bit 0 = wide access, bit 1 = mirror). Writing code 0 or 2 also loads the current column or line from the clamped start. Writing the mode reloads both counters from their clamped starts. Codes 5 to 7 have no effect.
- R3: Each access that is not a dummy read increments the column. If the column is already at or beyond the effective column end, it reloads the effective column start, and the line advances.
- R4: When the line advances while at or beyond the effective line end, it reloads the effective line start; otherwise it increments by one.
- R5: In wide access (mode bit 0 = 1) the column range is 0..127. Start and end values above 127 act as 127.
- R6: In narrow access (mode bit 0 = 0) the column range is 0..255.
- R7: Line start and end values above 161 act as 161, so ram_row never exceeds 161.
- R8: An end value below its start acts as equal to the start, giving a window at least one column wide and one line high.
- R9: With mode bit 1 = 1, ram_col = (column maximum of the current width) minus the internal column. With mode bit 1 = 0, ram_col equals the internal column.
- R10: The first read after reset, an address register load (code 0 or 2), a mode write or a write access is a dummy: the address holds and read_fresh stays 0. Later reads advance the address and assert read_fresh during the strobe.
- R11: A register write takes priority. An access strobe in the same cycle is ignored. Without a strobe or a register write the address holds.
- R12: ram_row and ram_col are registered. They show the result of a strobe or register write in the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 3 | Register select code |
| cfg_data | input | 8 | Register write data |
| acc_stb | input | 1 | Memory access strobe, one access per cycle |
| acc_rd | input | 1 | Access is a read (1) or a write (0) |
| ram_col | output | 8 | Memory column address after mirroring |
| ram_row | output | 8 | Memory line address |
| read_fresh | output | 1 | The current read strobe returns valid data |

## Verification
A wrong counter or bound shows on ram_col or ram_row on the first clock after the faulty step. The bench compares both ports with its model on every cycle, so an edge or wrap error is reported at the exact access where it occurs. A wrong dummy-read flag shows as a read_fresh mismatch during the strobe itself. It is followed one cycle later by an address that moved, or failed to move. A clamp fault shows only when a start or end register holds a value outside the valid area, so those values are driven on purpose in both access widths.

// File: rtl/wac_pkg.sv
package wac_pkg;
    typedef enum logic [2:0] {
        SEL_XS   = 3'd0,
        SEL_XE   = 3'd1,
        SEL_YS   = 3'd2,
        SEL_YE   = 3'd3,
        SEL_MODE = 3'd4
    } cfg_sel_e;
endpackage

// File: rtl/wac_bound.sv
module wac_bound #(
    parameter int W = 8
) (
    input  logic [W-1:0] lim,
    input  logic [W-1:0] start_raw,
    input  logic [W-1:0] end_raw,
    output logic [W-1:0] start_eff,
    output logic [W-1:0] end_eff
);
    logic [W-1:0] end_lim;

    always_comb begin
        start_eff = (start_raw > lim) ? lim : start_raw;
        end_lim   = (end_raw > lim) ? lim : end_raw;
        end_eff   = (end_lim < start_eff) ? start_eff : end_lim;
    end
endmodule

// File: rtl/wac_step.sv
module wac_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] first,
    input  logic [W-1:0] last,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    always_comb begin
        wrap = (cur >= last);
        nxt  = wrap ? first : cur + W'(1);
    end
endmodule

// File: rtl/wac_mirror.sv
module wac_mirror #(
    parameter int W = 8
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] lim,
    input  logic         flip,
    output logic [W-1:0] col
);
    always_comb begin
        col = flip ? (lim - pos) : pos;
    end
endmodule

// File: rtl/wac_top.sv
module wac_top #(
    parameter int COLS  = 128,
    parameter int LINES = 162,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_data,
    input  logic          acc_stb,
    input  logic          acc_rd,
    output logic [AW-1:0] ram_col,
    output logic [AW-1:0] ram_row,
    output logic          read_fresh
);
    import wac_pkg::*;

    localparam logic [AW-1:0] XMAX_WIDE   = AW'(COLS - 1);
    localparam logic [AW-1:0] XMAX_NARROW = AW'(2 * COLS - 1);
    localparam logic [AW-1:0] YMAX        = AW'(LINES - 1);

    typedef struct packed {
        logic [AW-1:0] xs;
        logic [AW-1:0] xe;
        logic [AW-1:0] ys;
        logic [AW-1:0] ye;
        logic [AW-1:0] x;
        logic [AW-1:0] y;
        logic          wide;
        logic          mir;
        logic          prime;
    } st_t;

    st_t st_d, st_q;

    logic [AW-1:0] xlim_w, xlim_new_w;
    logic [AW-1:0] xs_eff_w, xe_eff_w, ys_eff_w, ye_eff_w;
    logic [AW-1:0] x_nxt_w, y_nxt_w;
    logic          x_wrap_w, y_wrap_w;
    logic          do_acc_w, dummy_w;
    logic          wide_w;

    assign xlim_w     = st_q.wide ? XMAX_WIDE : XMAX_NARROW;
    assign xlim_new_w = cfg_data[0] ? XMAX_WIDE : XMAX_NARROW;
    assign wide_w     = st_q.wide;

    wac_bound #(.W(AW)) u_xbound (
        .lim       (xlim_w),
        .start_raw (st_q.xs),
        .end_raw   (st_q.xe),
        .start_eff (xs_eff_w),
        .end_eff   (xe_eff_w)
    );

    wac_bound #(.W(AW)) u_ybound (
        .lim       (YMAX),
        .start_raw (st_q.ys),
        .end_raw   (st_q.ye),
        .start_eff (ys_eff_w),
        .end_eff   (ye_eff_w)
    );

    wac_step #(.W(AW)) u_xstep (
        .cur   (st_q.x),
        .first (xs_eff_w),
        .last  (xe_eff_w),
        .nxt   (x_nxt_w),
        .wrap  (x_wrap_w)
    );

    wac_step #(.W(AW)) u_ystep (
        .cur   (st_q.y),
        .first (ys_eff_w),
        .last  (ye_eff_w),
        .nxt   (y_nxt_w),
        .wrap  (y_wrap_w)
    );

    wac_mirror #(.W(AW)) u_mirror (
        .pos  (st_q.x),
        .lim  (xlim_w),
        .flip (st_q.mir),
        .col  (ram_col)
    );

    assign ram_row    = st_q.y;
    assign do_acc_w   = acc_stb & ~cfg_we;
    assign dummy_w    = do_acc_w & acc_rd & st_q.prime;
    assign read_fresh = do_acc_w & acc_rd & ~st_q.prime;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_XS: begin
                    st_d.xs    = cfg_data;
                    st_d.x     = (cfg_data > xlim_w) ? xlim_w : cfg_data;
                    st_d.prime = 1'b1;
                end
                SEL_XE: st_d.xe = cfg_data;
                SEL_YS: begin
                    st_d.ys    = cfg_data;
                    st_d.y     = (cfg_data > YMAX) ? YMAX : cfg_data;
                    st_d.prime = 1'b1;
                end
                SEL_YE: st_d.ye = cfg_data;
                SEL_MODE: begin
                    st_d.wide  = cfg_data[0];
                    st_d.mir   = cfg_data[1];
                    st_d.x     = (st_q.xs > xlim_new_w) ? xlim_new_w : st_q.xs;
                    st_d.y     = ys_eff_w;
                    st_d.prime = 1'b1;
                end
                default: st_d = st_q;
            endcase
        end else if (do_acc_w) begin
            if (dummy_w) begin
                st_d.prime = 1'b0;
            end else begin
                st_d.x = x_nxt_w;
                if (x_wrap_w) begin
                    st_d.y = y_nxt_w;
                end
                if (!acc_rd) begin
                    st_d.prime = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.xe    <= '1;
            st_q.ye    <= '1;
            st_q.prime <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wac_chk.sv
module wac_chk #(
    parameter int COLS  = 128,
    parameter int LINES = 162,
    parameter int AW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [2:0]    cfg_sel,
    input logic          acc_stb,
    input logic          acc_rd,
    input logic [AW-1:0] ram_col,
    input logic [AW-1:0] ram_row,
    input logic          read_fresh,
    input logic          wide
);
    AST_ROW_IN_AREA: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ram_row) <= LINES - 1);                                              // R7
    AST_WIDE_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wide |-> int'(ram_col) <= COLS - 1);                                      // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !acc_stb) |=> ($stable(ram_col) && $stable(ram_row)));       // R11
    AST_LOAD_PRIMES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 3'd0) |=> !read_fresh);                             // R10
    AST_WRITE_PRIMES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !acc_rd && !cfg_we) |=> !read_fresh);                         // R10
    AST_DUMMY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && acc_rd && !cfg_we && !read_fresh)
        |=> ($stable(ram_col) && $stable(ram_row)));                              // R10
endmodule

bind wac_top wac_chk #(.COLS(COLS), .LINES(LINES), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .acc_stb    (acc_stb),
    .acc_rd     (acc_rd),
    .ram_col    (ram_col),
    .ram_row    (ram_row),
    .read_fresh (read_fresh),
    .wide       (wide_w)
);

// File: tb/wac_top_tb.sv
module wac_top_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [2:0] cfg_sel;
    logic [7:0] cfg_data;
    logic       acc_stb;
    logic       acc_rd;
    logic [7:0] ram_col;
    logic [7:0] ram_row;
    logic       read_fresh;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int m_xs, m_xe, m_ys, m_ye, m_x, m_y, m_wide, m_mir, m_prime;

    always #2 clk = ~clk;

    wac_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .acc_stb    (acc_stb),
        .acc_rd     (acc_rd),
        .ram_col    (ram_col),
        .ram_row    (ram_row),
        .read_fresh (read_fresh)
    );

    function automatic int mn(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int col_top(int w);
        return w ? 127 : 255;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_xs = 0; m_xe = 255; m_ys = 0; m_ye = 255;
        m_x = 0; m_y = 0; m_wide = 0; m_mir = 0; m_prime = 1;
    endtask

    task automatic model_step(bit we, int sel, int data, bit stb, bit rd);
        int lim, exs, exe, eys, eye;
        lim = col_top(m_wide);
        if (we) begin
            if (sel == 0) begin
                m_xs = data; m_x = mn(data, lim); m_prime = 1;
            end else if (sel == 1) begin
                m_xe = data;
            end else if (sel == 2) begin
                m_ys = data; m_y = mn(data, 161); m_prime = 1;
            end else if (sel == 3) begin
                m_ye = data;
            end else if (sel == 4) begin
                m_wide = data & 1; m_mir = (data >> 1) & 1;
                m_x = mn(m_xs, col_top(m_wide)); m_y = mn(m_ys, 161); m_prime = 1;
            end
        end else if (stb) begin
            if (rd && m_prime) begin
                m_prime = 0;
            end else begin
                exs = mn(m_xs, lim);
                exe = mx(mn(m_xe, lim), exs);
                if (m_x >= exe) begin
                    m_x = exs;
                    eys = mn(m_ys, 161);
                    eye = mx(mn(m_ye, 161), eys);
                    if (m_y >= eye) m_y = eys;
                    else m_y = m_y + 1;
                end else begin
                    m_x = m_x + 1;
                end
                if (!rd) m_prime = 1;
            end
        end
    endtask

    task automatic check_addr(string tag);
        int exp_col;
        exp_col = m_mir ? (col_top(m_wide) - m_x) : m_x;
        chk(tag, "ram_col", int'(ram_col), exp_col);
        chk(tag, "ram_row", int'(ram_row), m_y);
    endtask

    // called at a negedge: compare, drive, check comb flag, clock, update model
    task automatic cyc(string tag, bit we, int sel, int data, bit stb, bit rd);
        check_addr(tag);
        cfg_we = we; cfg_sel = 3'(sel); cfg_data = 8'(data);
        acc_stb = stb; acc_rd = rd;
        #1;
        chk(tag, "read_fresh", int'(read_fresh), int'(stb && rd && !we && !m_prime));
        @(posedge clk);
        model_step(we, sel, data, stb, rd);
        @(negedge clk);
    endtask

    task automatic wr(string tag, int sel, int data);
        cyc(tag, 1, sel, data, 0, 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int lf;
        rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_data = 0; acc_stb = 0; acc_rd = 0;
        model_reset();
        repeat (3) @(negedge clk);
        check_addr("R1");
        rst_n = 1;
        // R1: first read after reset is a dummy
        cyc("R1", 0, 0, 0, 1, 1);
        cyc("R10", 0, 0, 0, 1, 1);
        // R6: narrow range, column wraps at 255 and line advances
        for (int i = 0; i < 260; i++) cyc("R6", 0, 0, 0, 1, 0);
        // R2, R3, R4: small window
        wr("R2", 0, 2); wr("R2", 1, 4); wr("R2", 2, 5); wr("R2", 3, 6);
        for (int i = 0; i < 8; i++) cyc("R3", 0, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) cyc("R4", 0, 0, 0, 1, 0);
        wr("R2", 6, 99); wr("R2", 7, 1);
        // R10: dummy after load, then fresh reads, dummy again after a write
        wr("R10", 2, 5);
        for (int i = 0; i < 4; i++) cyc("R10", 0, 0, 0, 1, 1);
        cyc("R10", 0, 0, 0, 1, 0);
        for (int i = 0; i < 3; i++) cyc("R10", 0, 0, 0, 1, 1);
        // R5: wide access with out-of-area start and end
        wr("R5", 4, 1); wr("R5", 0, 200); wr("R5", 1, 250);
        for (int i = 0; i < 3; i++) cyc("R5", 0, 0, 0, 1, 0);
        wr("R5", 0, 120); wr("R5", 1, 255);
        for (int i = 0; i < 10; i++) cyc("R5", 0, 0, 0, 1, 0);
        // R9: mirror in wide and narrow access
        wr("R9", 4, 3); wr("R9", 0, 0); wr("R9", 1, 3);
        for (int i = 0; i < 6; i++) cyc("R9", 0, 0, 0, 1, 0);
        wr("R9", 4, 2);
        for (int i = 0; i < 6; i++) cyc("R9", 0, 0, 0, 1, 0);
        // R7: line values beyond the panel
        wr("R7", 4, 0); wr("R7", 2, 170); wr("R7", 3, 200); wr("R7", 1, 1);
        for (int i = 0; i < 5; i++) cyc("R7", 0, 0, 0, 1, 0);
        // R8: end below start
        wr("R8", 0, 10); wr("R8", 1, 5); wr("R8", 2, 20); wr("R8", 3, 3);
        for (int i = 0; i < 4; i++) cyc("R8", 0, 0, 0, 1, 0);
        // R11: register write wins over a strobe; idle holds
        wr("R11", 1, 40);
        cyc("R11", 1, 3, 30, 1, 0);
        cyc("R11", 1, 0, 7, 1, 1);
        for (int i = 0; i < 3; i++) cyc("R11", 0, 0, 0, 0, 0);
        // R12: pseudo-random mixture compared every cycle
        lf = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            lf = lf * 1103515245 + 12345;
            if (((lf >> 24) & 15) == 0)
                cyc("R12", 1, (lf >> 8) & 7, (lf >> 12) & 255, (lf >> 20) & 1, 0);
            else
                cyc("R12", 0, 0, 0, (lf >> 21) & 1, (lf >> 22) & 1);
        end
        check_addr("R12");
        summary();
    end
endmodule